// File: doc/BRIEF.md
# Serial Save-Memory Emulator on a Shared Joypad Port

This block stands in for a bit-serial backup memory cartridge that sits between a game console and its joypad. The console drives two lines into the port: a clock line (CLR) and a data/select line (SEL). Each bit period opens on a CLR rise and closes on the next CLR fall. SEL carries the console's data bit, sampled when CLR rises, and must not move while CLR is high. While idle, the block gathers the SEL bits into bytes, least significant bit first. When a byte equals 0xA8, the block raises a select output. That output steers an external 2:1 multiplexer, so the console's return nibble now comes from the block instead of from the joypad.

Once armed, the block takes a command made of three fields: a direction flag, a sector number and a bit count. It then streams that many bits between the console and an internal byte-wide store. When the command ends, the multiplexer goes back to the joypad. A write command is followed by two extra clock periods, and the block holds the port until both have passed. A read has no such tail. Its first data bit comes from a fetch that starts on the last bit of the count field, so the bit is ready before the next CLR-high window.

Top module: `serial_save_emu`

## Requirements
- R1: While reset is held, and right after it is released, `mux_sel_o` is 0 and `nib_o` is 0x0.
- R2: While idle, the SEL level at each CLR rise is taken as the next bit of a byte, least significant bit first. The block counts eight bits per byte from reset. A byte equal to 0xA8 sets `mux_sel_o` to 1 before the middle of that eighth CLR-high window. Any other byte leaves `mux_sel_o` at 0 and starts a new byte.
- R3: While `mux_sel_o` is 1, `nib_o` is {0, SEL level, 0, read bit}, with the read bit on bit 0. Outside a read data phase the read bit is 0. So the detection read returns 0x4 when the console drives SEL high, and 0x0 when it drives SEL low.
- R4: After arming, a command is read from the SEL bits in this order, and each field is least significant bit first:
  - one direction bit (1 = read, 0 = write);
  - a 10-bit sector number;
  - a 20-bit bit count;
  - then exactly that many data bits.
- R5: Data bit k of a command lives in bit (k mod 8) of byte address sector*128 + k/8. This address is taken modulo the store size of 2^MEM_AW bytes, which is 128 KB when MEM_AW is 17.
- R6: A write stores each data bit at its address. When the last byte is only partly covered, the bits in it that the command does not reach keep their old values.
- R7: On a read, `nib_o[0]` carries data bit k from the CLR fall that ends the previous period, and holds it steady through the whole CLR-high window of period k. For k = 0, the previous period is the last bit of the count field.
- R8: After the last data bit of a write, `mux_sel_o` stays 1 for two more full CLR periods. It drops at the second CLR fall. The SEL levels in those two periods are never stored.
- R9: A read drops `mux_sel_o` at the CLR fall that ends its last data bit. A read with a count of zero drops it at the fall that ends the last bit of the count field.
- R10: If SEL changes while CLR is high, the command is abandoned. The block returns to idle with `mux_sel_o` at 0, and the next idle bit starts a fresh byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, at least 20 times the console bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Console clock line (asynchronous) |
| sel_i | input | 1 | Console data/select line (asynchronous) |
| mux_sel_o | output | 1 | 1 steers the port nibble to the block, 0 to the joypad |
| nib_o | output | 4 | Nibble returned to the console while selected |

## Verification
On a write, the eighth bit of each byte does two things on the same CLR rise. It commits the finished byte to the store, and it starts the fetch of the next byte, whose old contents are needed for a partial final byte. The two operations go to different addresses in the same cycle. Random bit counts from 1 to 48 cross byte boundaries at varying offsets. A directed short write lands inside a byte that was fully written before, and its two tail bits drive the inverse of the stored bits that follow it. Each case is judged by reading the region back bit by bit against a model of the store that tracks which bits are known. A checker also requires that a commit and a fetch in the same cycle never point at the same byte.

// File: rtl/serial_save_pkg.sv
`timescale 1ns/1ps
package serial_save_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR,
    ST_ADDR,
    ST_CNT,
    ST_DATA,
    ST_FLUSH
  } sv_state_e;

  // Byte address of byte index bidx inside sector sect (before wrapping).
  function automatic logic [31:0] sector_byte(input logic [31:0] sect,
                                              input logic [31:0] bidx,
                                              input int unsigned shift);
    return (sect << shift) + bidx;
  endfunction

endpackage

// File: rtl/serial_save_sync.sv
`timescale 1ns/1ps
module serial_save_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] stg [STAGES];
  logic [W-1:0] dly;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) dly <= '0;
    else        dly <= stg[STAGES-1];

  assign lvl  = stg[STAGES-1];
  assign rise = stg[STAGES-1] & ~dly;
  assign fall = ~stg[STAGES-1] & dly;
endmodule

// File: rtl/serial_save_store.sv
`timescale 1ns/1ps
module serial_save_store #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
    if (rd_en) rd_data <= cells[rd_addr];
  end
endmodule

// File: rtl/serial_save_ctrl.sv
`timescale 1ns/1ps
module serial_save_ctrl
  import serial_save_pkg::*;
#(
  parameter int         SECT_W     = 10,
  parameter int         CNT_W      = 20,
  parameter int         MEM_AW     = 11,
  parameter int         SECT_SHIFT = 7,
  parameter logic [7:0] ATTN       = 8'hA8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_lvl,
  input  logic              clr_rise,
  input  logic              clr_fall,
  input  logic              sel_lvl,
  input  logic              sel_rise,
  input  logic              sel_fall,
  output logic              mux_sel,
  output logic              tx_bit,
  output logic              attn_hit,
  output logic              frame_err,
  output logic              release_ev,
  output logic              rd_en,
  output logic [MEM_AW-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              wr_en,
  output logic [MEM_AW-1:0] wr_addr,
  output logic [7:0]        wr_data
);
  localparam int SI_W   = $clog2(SECT_W);
  localparam int CI_W   = $clog2(CNT_W);
  localparam int FCNT_W = (CI_W > 3) ? CI_W : 3;

  sv_state_e         state;
  logic [FCNT_W-1:0] fcnt;
  logic [7:0]        ibyte;
  logic [7:0]        ibyte_nxt;
  logic              dir;
  logic [SECT_W-1:0] sect;
  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  d;
  logic [CNT_W-1:0]  d_nxt;
  logic [7:0]        wbuf;
  logic [7:0]        wbyte;
  logic              fl;
  logic              data_rise;
  logic              last_bit;
  logic              cnt_last;

  assign ibyte_nxt = {sel_lvl, ibyte[7:1]};
  assign d_nxt     = d + CNT_W'(1);
  assign last_bit  = (d_nxt == count);
  assign data_rise = (state == ST_DATA) && clr_rise && (d != count);
  assign cnt_last  = (state == ST_CNT) && clr_rise && (fcnt == FCNT_W'(CNT_W - 1));

  assign mux_sel   = (state != ST_IDLE);
  assign frame_err = clr_lvl && !clr_rise && (sel_rise || sel_fall);
  assign attn_hit  = (state == ST_IDLE) && clr_rise && (fcnt == FCNT_W'(7)) &&
                     (ibyte_nxt == ATTN);
  assign release_ev = clr_fall &&
                      (((state == ST_DATA) && (d == count) && dir) ||
                       ((state == ST_FLUSH) && fl));

  always_comb begin
    wbyte = wbuf;
    wbyte[d[2:0]] = sel_lvl;
  end

  always_comb begin
    rd_en   = 1'b0;
    rd_addr = MEM_AW'(sector_byte(32'(sect), 32'd0, SECT_SHIFT));
    if (cnt_last) begin
      rd_en = 1'b1;
    end else if (data_rise && (d_nxt[2:0] == 3'd0) && !last_bit) begin
      rd_en   = 1'b1;
      rd_addr = MEM_AW'(sector_byte(32'(sect), 32'(d_nxt >> 3), SECT_SHIFT));
    end
  end

  assign wr_en   = data_rise && !dir && ((d[2:0] == 3'd7) || last_bit);
  assign wr_addr = MEM_AW'(sector_byte(32'(sect), 32'(d >> 3), SECT_SHIFT));
  assign wr_data = wbyte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      fcnt   <= '0;
      ibyte  <= '0;
      dir    <= 1'b0;
      sect   <= '0;
      count  <= '0;
      d      <= '0;
      tx_bit <= 1'b0;
      wbuf   <= '0;
      fl     <= 1'b0;
    end else if (frame_err) begin
      state  <= ST_IDLE;
      fcnt   <= '0;
      tx_bit <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (clr_rise) begin
          ibyte <= ibyte_nxt;
          if (fcnt == FCNT_W'(7)) begin
            fcnt <= '0;
            if (attn_hit) state <= ST_DIR;
          end else begin
            fcnt <= fcnt + FCNT_W'(1);
          end
        end
        ST_DIR: if (clr_rise) begin
          dir   <= sel_lvl;
          fcnt  <= '0;
          count <= '0;
          state <= ST_ADDR;
        end
        ST_ADDR: if (clr_rise) begin
          sect[fcnt[SI_W-1:0]] <= sel_lvl;
          if (fcnt == FCNT_W'(SECT_W - 1)) begin
            fcnt  <= '0;
            state <= ST_CNT;
          end else begin
            fcnt <= fcnt + FCNT_W'(1);
          end
        end
        ST_CNT: if (clr_rise) begin
          count[fcnt[CI_W-1:0]] <= sel_lvl;
          if (cnt_last) begin
            fcnt  <= '0;
            d     <= '0;
            state <= ST_DATA;
          end else begin
            fcnt <= fcnt + FCNT_W'(1);
          end
        end
        ST_DATA: begin
          if (data_rise) begin
            d <= d_nxt;
            if (!dir) wbuf <= wbyte;
          end
          if (clr_fall) begin
            if (d == count) begin
              tx_bit <= 1'b0;
              fl     <= 1'b0;
              state  <= dir ? ST_IDLE : ST_FLUSH;
            end else if (dir) begin
              tx_bit <= rd_data[d[2:0]];
            end else if (d[2:0] == 3'd0) begin
              wbuf <= rd_data;
            end
          end
        end
        ST_FLUSH: if (clr_fall) begin
          if (fl) state <= ST_IDLE;
          else    fl    <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serial_save_emu.sv
`timescale 1ns/1ps
module serial_save_emu #(
  parameter int         SECT_W      = 10,
  parameter int         CNT_W       = 20,
  parameter int         MEM_AW      = 11,
  parameter int         SECT_SHIFT  = 7,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] ATTN        = 8'hA8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic       sel_i,
  output logic       mux_sel_o,
  output logic [3:0] nib_o
);
  logic [1:0]        s_lvl, s_rise, s_fall;
  logic              clr_lvl, clr_rise, clr_fall;
  logic              sel_lvl, sel_rise, sel_fall;
  logic              tx_bit, attn_hit, frame_err, release_ev;
  logic              rd_en, wr_en;
  logic [MEM_AW-1:0] rd_addr, wr_addr;
  logic [7:0]        rd_data, wr_data;

  serial_save_sync #(.W(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .din({sel_i, clr_i}),
    .lvl(s_lvl), .rise(s_rise), .fall(s_fall)
  );

  assign clr_lvl  = s_lvl[0];
  assign clr_rise = s_rise[0];
  assign clr_fall = s_fall[0];
  assign sel_lvl  = s_lvl[1];
  assign sel_rise = s_rise[1];
  assign sel_fall = s_fall[1];

  serial_save_ctrl #(
    .SECT_W(SECT_W), .CNT_W(CNT_W), .MEM_AW(MEM_AW),
    .SECT_SHIFT(SECT_SHIFT), .ATTN(ATTN)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .clr_lvl(clr_lvl), .clr_rise(clr_rise), .clr_fall(clr_fall),
    .sel_lvl(sel_lvl), .sel_rise(sel_rise), .sel_fall(sel_fall),
    .mux_sel(mux_sel_o), .tx_bit(tx_bit), .attn_hit(attn_hit),
    .frame_err(frame_err), .release_ev(release_ev),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  serial_save_store #(.AW(MEM_AW)) store_i (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  assign nib_o = mux_sel_o ? {1'b0, sel_lvl, 1'b0, tx_bit} : 4'h0;
endmodule

// File: rtl/serial_save_chk.sv
`timescale 1ns/1ps
module serial_save_chk #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr_lvl,
  input logic          mux_sel_o,
  input logic          tx_bit,
  input logic          attn_hit,
  input logic          frame_err,
  input logic          release_ev,
  input logic          rd_en,
  input logic [AW-1:0] rd_addr,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr
);
  // R2
  arm_only_on_attn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mux_sel_o) |-> $past(attn_hit));

  // R10
  abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !mux_sel_o);

  // R9
  release_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mux_sel_o) |-> $past(release_ev || frame_err));

  // R7
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_lvl && $past(clr_lvl) && !$past(frame_err)) |-> $stable(tx_bit));

  // R6
  commit_fetch_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en) |-> (wr_addr != rd_addr));
endmodule

bind serial_save_emu serial_save_chk #(.AW(MEM_AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .clr_lvl(clr_lvl), .mux_sel_o(mux_sel_o),
  .tx_bit(tx_bit), .attn_hit(attn_hit), .frame_err(frame_err),
  .release_ev(release_ev), .rd_en(rd_en), .rd_addr(rd_addr),
  .wr_en(wr_en), .wr_addr(wr_addr)
);

// File: tb/serial_save_emu_tb_top.sv
`timescale 1ns/1ps
module serial_save_emu_tb_top;
  localparam int H    = 40;
  localparam int AW   = 11;
  localparam int MEMB = 1 << AW;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic       sel = 1'b0;
  logic       mux;
  logic [3:0] nib;

  always #2.5 clk = ~clk;

  serial_save_emu #(.MEM_AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .sel_i(sel),
    .mux_sel_o(mux), .nib_o(nib)
  );

  logic [7:0] mem_m [MEMB];
  logic [7:0] kn_m  [MEMB];
  logic [7:0] wdat  [8];
  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  function automatic int maddr(int s, int i);
    return (s * 128 + i) % MEMB;
  endfunction

  task automatic wait_c(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bit_hi(input logic b, output logic [3:0] nmid, output logic mmid);
    sel = b;
    wait_c(H);
    clr = 1'b1;
    wait_c(H / 2);
    nmid = nib;
    mmid = mux;
    wait_c(H / 2);
    clr = 1'b0;
  endtask

  task automatic bit_pl(input logic b);
    logic [3:0] n;
    logic       m;
    bit_hi(b, n, m);
  endtask

  task automatic send_val(logic [31:0] v, int n);
    for (int i = 0; i < n; i++) bit_pl(v[i]);
  endtask

  task automatic arm();
    logic [3:0] n;
    logic       m;
    logic [7:0] a = 8'hA8;
    for (int i = 0; i < 8; i++) begin
      bit_hi(a[i], n, m);
      if (i == 6) chk("R2 not armed before eighth bit", {31'b0, m}, 32'd0);
      if (i == 7) chk("R2 armed on attention byte", {31'b0, m}, 32'd1);
    end
    wait_c(8);
    sel = 1'b1;
    wait_c(8);
    chk("R3 detection nibble", {28'b0, nib}, 32'h4);
    sel = 1'b0;
    wait_c(8);
    chk("R3 nibble follows data line low", {28'b0, nib}, 32'h0);
  endtask

  task automatic header(logic dr, int s, int c);
    arm();
    bit_pl(dr);
    send_val(s, 10);
    send_val(c, 20);
  endtask

  task automatic do_write(int s, int nb);
    logic [3:0] n;
    logic       m;
    logic       b;
    logic       fb;
    int         a;
    int         p;
    header(1'b0, s, nb);
    for (int k = 0; k < nb; k++) begin
      b = wdat[k / 8][k % 8];
      bit_pl(b);
      a = maddr(s, k / 8);
      mem_m[a][k % 8] = b;
      kn_m[a][k % 8]  = 1'b1;
    end
    wait_c(8);
    chk("R8 port held after last write bit", {31'b0, mux}, 32'd1);
    for (int j = 0; j < 2; j++) begin
      p  = nb + j;
      a  = maddr(s, p / 8);
      fb = kn_m[a][p % 8] ? ~mem_m[a][p % 8] : 1'b1;
      bit_hi(fb, n, m);
      chk("R8 port held during flush bit", {31'b0, m}, 32'd1);
    end
    wait_c(8);
    chk("R8 port released after two flush bits", {31'b0, mux}, 32'd0);
  endtask

  task automatic do_read(int s, int nb, string tag);
    logic [3:0] n;
    logic       m;
    int         a;
    header(1'b1, s, nb);
    for (int k = 0; k < nb; k++) begin
      bit_hi(1'b0, n, m);
      a = maddr(s, k / 8);
      if (kn_m[a][k % 8])
        chk({tag, " R4 R5 R7 read bit"}, {31'b0, n[0]}, {31'b0, mem_m[a][k % 8]});
      if (k == nb - 1) chk("R9 port held on last read bit", {31'b0, m}, 32'd1);
    end
    wait_c(8);
    chk("R9 port released after read", {31'b0, mux}, 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] n;
    logic       m;
    logic [7:0] nb8;
    logic [31:0] pat;
    int s;
    int nb;
    void'($urandom(32'd1234));
    for (int i = 0; i < MEMB; i++) begin
      mem_m[i] = 8'h00;
      kn_m[i]  = 8'h00;
    end

    wait_c(10);
    chk("R1 mux in reset", {31'b0, mux}, 32'd0);
    chk("R1 nibble in reset", {28'b0, nib}, 32'd0);
    rst_n = 1'b1;
    wait_c(10);
    chk("R1 mux after reset", {31'b0, mux}, 32'd0);
    chk("R1 nibble after reset", {28'b0, nib}, 32'd0);

    // full-byte write and readback
    pat = 32'hC3A5_0F96;
    for (int i = 0; i < 4; i++) wdat[i] = pat[8*i +: 8];
    do_write(3, 32);
    do_read(3, 32, "R6 full");

    // partial final byte, flush bits drive inverted neighbours
    wdat[0] = 8'h5A;
    wdat[1] = 8'h00;
    do_write(3, 13);
    do_read(3, 32, "R6 R8 partial");

    // sector number beyond store wraps
    for (int i = 0; i < 2; i++) wdat[i] = 8'($urandom);
    do_write(17, 16);
    do_read(1, 16, "R5 wrap");

    // zero-length read
    header(1'b1, 5, 0);
    wait_c(8);
    chk("R9 zero-length read releases", {31'b0, mux}, 32'd0);

    // framing abort in the sector field
    arm();
    bit_pl(1'b1);
    send_val(32'd2, 3);
    sel = 1'b0;
    wait_c(H);
    clr = 1'b1;
    wait_c(H / 2);
    sel = 1'b1;
    wait_c(10);
    chk("R10 abort releases port", {31'b0, mux}, 32'd0);
    chk("R10 abort nibble", {28'b0, nib}, 32'd0);
    wait_c(H / 2);
    clr = 1'b0;
    wait_c(H);

    // non-attention byte stays idle
    nb8 = 8'h2A;
    for (int i = 0; i < 8; i++) begin
      bit_hi(nb8[i], n, m);
      if (i == 7) chk("R2 non-attention byte ignored", {31'b0, m}, 32'd0);
    end
    do_read(3, 16, "R10 realign");

    // random commands
    for (int r = 0; r < 3; r++) begin
      s  = $urandom_range(0, 15);
      nb = $urandom_range(1, 48);
      for (int i = 0; i < 8; i++) wdat[i] = 8'($urandom);
      do_write(s, nb);
      do_read(s, nb, "R6 random");
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule